// File: doc/BRIEF.md
# DAC Sample FIFO with Swing-Back

This block holds the sample codes that feed a digital-to-analog converter and decides which code sits on the converter input at any time. Samples arrive on a write port from a processor or DMA engine. Conversion triggers arrive on a single-bit strobe. The block keeps one registered output code, plus a 16-entry store of 14-bit samples with read and write pointers.

Three operating modes are selected by a 2-bit input. In direct mode a write lands on the output register at once and triggers do nothing. In queue mode samples are stored in order, and each trigger moves the oldest one to the output. In swing-back mode the stored samples form a waveform table. Successive triggers walk the read pointer upward to the newest entry and then back down to zero, again and again, which produces a symmetric waveform from half a period of data. Sticky error flags catch triggers on an empty store and writes into a full one. Level flags report empty, full and a programmable low-water mark. An interrupt line and a DMA request line are formed from the flags and their enable masks.

Top module: `dac_sample_fifo`

## Requirements
- R1: With `mode_sel` equal to 0 or 3 (direct mode), a write sets `dout` to `wr_data` on the next cycle. A trigger leaves `dout`, both pointers and `status` unchanged.
- R2: With `mode_sel` equal to 1 (queue mode), an accepted write stores the sample at `wr_ptr` and advances `wr_ptr` modulo 16. A trigger on a non-empty store sets `dout` to the oldest stored sample on the next cycle and advances `rd_ptr` modulo 16.
- R3: A trigger while no sample is stored sets `status[0]` (underflow). `rd_ptr` and `dout` keep their values.
- R4: A write while 16 samples are stored sets `status[1]` (overflow). `wr_ptr` keeps its value and the sample is dropped.
- R5: A 1 in bit k of `flag_w1c` clears `status[k]` for k = 0..2. If the setting event for that flag occurs in the same cycle, the flag stays set.
- R6: With `mode_sel` equal to 2 (swing-back mode) and N samples stored, each trigger outputs the entry at `rd_ptr` and then steps `rd_ptr` up to N-1, then down to 0, and repeats. For N = 3 the sequence is 0,1,2,1,0,1,2.
- R7: In swing-back mode `status[2]` (sweep complete) sets when a trigger brings `rd_ptr` back down to 0. With three samples this happens on the fourth trigger. With one sample it happens on every trigger.
- R8: Outside swing-back mode, `status[3]` (watermark) is 1 whenever the stored count is at most `wm_level`, and 0 otherwise.
- R9: Outside swing-back mode, `status[4]` is 1 exactly when the store is empty and `status[5]` is 1 exactly when 16 samples are stored. After reset `status` reads 6'h18.
- R10: While swing-back mode is selected, `status[3]`, `status[4]` and `status[5]` hold their values.
- R11: `fifo_clr` zeroes both pointers and returns `status` to 6'h18, and it takes precedence over a write or trigger in the same cycle. `dout` is unchanged.
- R12: `soft_rst` (like `rst`) returns every register, including `dout`, to its reset value.
- R13: `irq` is the OR of `status & irq_en`. `dma_req` is `(dma_en[0] & status[3]) | (dma_en[1] & status[4])`.
- R14: A write and a trigger in the same cycle in queue mode both take effect. Empty and full are judged on the count before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous soft reset of all state |
| fifo_clr | input | 1 | Clears pointers and status flags |
| mode_sel | input | 2 | 0/3 direct, 1 queue, 2 swing-back |
| wm_level | input | 5 | Watermark threshold |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 14 | Sample code to write |
| trig | input | 1 | Conversion trigger |
| flag_w1c | input | 3 | Write-1-to-clear for status bits 2..0 |
| irq_en | input | 6 | Interrupt enable per status bit |
| dma_en | input | 2 | DMA enable: bit0 watermark, bit1 empty |
| dout | output | 14 | Code presented to the converter |
| wr_ptr | output | 4 | Write pointer |
| rd_ptr | output | 4 | Read pointer |
| status | output | 6 | {full, empty, watermark, sweep, overflow, underflow} |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A software clear of a sticky flag can land in the same cycle as the event that sets that flag. The directed case drives a trigger on an empty store together with `flag_w1c[0]` and expects underflow to remain set, then drives the clear alone and expects it to drop. The random phase produces further collisions at full and empty boundaries, and also the write-plus-trigger overlap of R14. Every cycle is judged against a bench reference model of the store that is built from the requirements.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int SAMPLE_W   = 14;
    localparam int WMARK_W    = 5;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_QUEUE  = 2'd1,
        MODE_SWING  = 2'd2,
        MODE_RSVD   = 2'd3
    } op_mode_e;

    // Sticky events raised by the pointer controller in one cycle.
    typedef struct packed {
        logic sweep;
        logic over;
        logic under;
    } evt_t;

    // Status word; under is bit 0, full is bit 5.
    typedef struct packed {
        logic full;
        logic empty;
        logic wmark;
        logic sweep;
        logic over;
        logic under;
    } flags_t;

    function automatic flags_t flags_idle();
        flags_t f;
        f       = '0;
        f.empty = 1'b1;
        f.wmark = 1'b1;
        return f;
    endfunction

    function automatic logic uses_store(op_mode_e m);
        return (m == MODE_QUEUE) || (m == MODE_SWING);
    endfunction

endpackage

// File: rtl/dsf_store.sv
module dsf_store
    import dsf_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int DATA_W = SAMPLE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dsf_ptr_ctrl.sv
module dsf_ptr_ctrl
    import dsf_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  op_mode_e      mode,
    input  logic          wr_req,
    input  logic          trig,
    output logic          store_we,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic          load_out,
    output evt_t          evt,
    output logic [CW-1:0] cnt_nxt
);

    logic [CW-1:0] wr_q, rd_q, wr_nx, rd_nx;
    logic          up_q, up_nx;
    logic [CW-1:0] occ;
    logic          is_queue, is_swing, active;
    logic          full_cur, empty_cur;
    logic [PW-1:0] top_idx, rd_inc;

    assign is_queue = (mode == MODE_QUEUE);
    assign is_swing = (mode == MODE_SWING);
    assign active   = uses_store(mode);

    assign occ       = wr_q - rd_q;
    // In swing-back mode the table occupies entries 0..wr_q-1.
    assign full_cur  = is_swing ? wr_q[PW] : (occ == CW'(DEPTH));
    assign empty_cur = is_swing ? (wr_q == '0) : (occ == '0);
    assign top_idx   = wr_q[PW] ? PW'(DEPTH - 1) : (wr_q[PW-1:0] - 1'b1);

    assign wr_idx = wr_q[PW-1:0];
    assign rd_idx = rd_q[PW-1:0];
    assign rd_inc = rd_idx + 1'b1;

    assign store_we  = active && wr_req && !full_cur;
    assign load_out  = active && trig && !empty_cur;
    assign evt.over  = active && wr_req && full_cur;
    assign evt.under = active && trig && empty_cur;

    always_comb begin
        rd_nx     = rd_q;
        up_nx     = up_q;
        evt.sweep = 1'b0;
        if (load_out) begin
            if (is_queue) begin
                rd_nx = rd_q + 1'b1;
            end else if (top_idx == '0) begin
                evt.sweep = 1'b1;
            end else if (up_q) begin
                rd_nx = rd_q + 1'b1;
                if (rd_inc == top_idx) begin
                    up_nx = 1'b0;
                end
            end else begin
                rd_nx = rd_q - 1'b1;
                if (rd_idx == PW'(1)) begin
                    up_nx     = 1'b1;
                    evt.sweep = 1'b1;
                end
            end
        end
    end

    assign wr_nx   = store_we ? (wr_q + 1'b1) : wr_q;
    assign cnt_nxt = wr_nx - rd_nx;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_q <= '0;
            rd_q <= '0;
            up_q <= 1'b1;
        end else begin
            wr_q <= wr_nx;
            rd_q <= rd_nx;
            up_q <= up_nx;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        is_queue |-> (occ <= CW'(DEPTH))) else $error("queue count above depth"); // R2

    AST_UNDERFLOW_HOLDS_RD: assert property (@(posedge clk) disable iff (rst)
        (is_queue && trig && empty_cur && !clr) |=> $stable(rd_q)) else $error("rd moved on underflow"); // R3

    AST_OVERFLOW_HOLDS_WR: assert property (@(posedge clk) disable iff (rst)
        (active && wr_req && full_cur && !clr) |=> $stable(wr_q)) else $error("wr moved on overflow"); // R4

    AST_SWEEP_ONLY_SWING: assert property (@(posedge clk) disable iff (rst)
        evt.sweep |-> is_swing) else $error("sweep event outside swing mode"); // R7

endmodule

// File: rtl/dsf_flags.sv
module dsf_flags
    import dsf_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int WM_W  = WMARK_W,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int XW   = CW + WM_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            freeze,
    input  evt_t            evt,
    input  logic [2:0]      w1c,
    input  logic [CW-1:0]   cnt_nxt,
    input  logic [WM_W-1:0] wm_level,
    output flags_t          flags
);

    flags_t        q;
    logic [XW-1:0] cnt_ext, wm_ext;

    assign cnt_ext = XW'(cnt_nxt);
    assign wm_ext  = XW'(wm_level);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= flags_idle();
        end else begin
            q.under <= evt.under | (q.under & ~w1c[0]);
            q.over  <= evt.over  | (q.over  & ~w1c[1]);
            q.sweep <= evt.sweep | (q.sweep & ~w1c[2]);
            if (!freeze) begin
                q.empty <= (cnt_nxt == '0);
                q.full  <= (cnt_nxt == CW'(DEPTH));
                q.wmark <= (cnt_ext <= wm_ext);
            end
        end
    end

    assign flags = q;

    AST_W1C_UNDER: assert property (@(posedge clk) disable iff (rst)
        (w1c[0] && !evt.under) |=> !q.under) else $error("underflow not cleared"); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (evt.over && !clr) |=> q.over) else $error("overflow lost to clear"); // R5

    AST_LEVELS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clr) |=> ($stable(q.empty) && $stable(q.full) && $stable(q.wmark)))
        else $error("level flag moved in swing mode"); // R10

    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(q.empty && q.full)) else $error("empty and full together"); // R9

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
    import dsf_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int DATA_W = SAMPLE_W,
    parameter int WM_W   = WMARK_W,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              fifo_clr,
    input  logic [1:0]        mode_sel,
    input  logic [WM_W-1:0]   wm_level,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig,
    input  logic [2:0]        flag_w1c,
    input  logic [5:0]        irq_en,
    input  logic [1:0]        dma_en,
    output logic [DATA_W-1:0] dout,
    output logic [PW-1:0]     wr_ptr,
    output logic [PW-1:0]     rd_ptr,
    output logic [5:0]        status,
    output logic              irq,
    output logic              dma_req
);

    op_mode_e          mode;
    logic              any_rst;
    logic              store_we, load_out;
    logic [PW-1:0]     wr_idx, rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic [CW-1:0]     cnt_nxt;
    evt_t              evt;
    flags_t            flags_q;
    logic              direct;

    assign mode    = op_mode_e'(mode_sel);
    assign any_rst = rst || soft_rst;
    assign direct  = !uses_store(mode);

    dsf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (store_we && !fifo_clr && !any_rst),
        .waddr (wr_idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_word)
    );

    dsf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (any_rst),
        .clr      (fifo_clr),
        .mode     (mode),
        .wr_req   (wr_en),
        .trig     (trig),
        .store_we (store_we),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .load_out (load_out),
        .evt      (evt),
        .cnt_nxt  (cnt_nxt)
    );

    dsf_flags #(.DEPTH(DEPTH), .WM_W(WM_W)) u_flags (
        .clk      (clk),
        .rst      (any_rst),
        .clr      (fifo_clr),
        .freeze   (mode == MODE_SWING),
        .evt      (evt),
        .w1c      (flag_w1c),
        .cnt_nxt  (cnt_nxt),
        .wm_level (wm_level),
        .flags    (flags_q)
    );

    always_ff @(posedge clk) begin
        if (any_rst) begin
            dout <= '0;
        end else if (fifo_clr) begin
            dout <= dout;
        end else if (direct && wr_en) begin
            dout <= wr_data;
        end else if (load_out) begin
            dout <= rd_word;
        end
    end

    assign wr_ptr  = wr_idx;
    assign rd_ptr  = rd_idx;
    assign status  = flags_q;
    assign irq     = |(status & irq_en);
    assign dma_req = (dma_en[0] & flags_q.wmark) | (dma_en[1] & flags_q.empty);

    AST_DIRECT_TRIG_IGNORED: assert property (@(posedge clk) disable iff (any_rst)
        (direct && trig && !wr_en) |=> $stable(dout)) else $error("trigger moved output in direct mode"); // R1

    AST_CLEAR_KEEPS_OUTPUT: assert property (@(posedge clk) disable iff (any_rst)
        fifo_clr |=> ($stable(dout) && (wr_ptr == '0) && (rd_ptr == '0))) else $error("fifo clear misbehaved"); // R11

endmodule

// File: tb/tb_dac_sample_fifo.sv
module tb_dac_sample_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1, soft_rst = 1'b0, fifo_clr = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [4:0]  wm_level = 5'd0;
    logic        wr_en = 1'b0, trig = 1'b0;
    logic [13:0] wr_data = '0;
    logic [2:0]  flag_w1c = '0;
    logic [5:0]  irq_en = '0;
    logic [1:0]  dma_en = '0;
    logic [13:0] dout;
    logic [3:0]  wr_ptr, rd_ptr;
    logic [5:0]  status;
    logic        irq, dma_req;

    dac_sample_fifo dut (.*);

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state
    int       m_mem [16];
    int       m_wr, m_rd, m_cnt, m_swn, m_dout;
    bit       m_up;
    bit [5:0] m_st;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit [5:0] sticky(bit [5:0] s, bit [2:0] ev, bit [2:0] c);
        bit [5:0] r = s;
        for (int k = 0; k < 3; k++) r[k] = ev[k] | (s[k] & ~c[k]);
        return r;
    endfunction

    task automatic model_edge();
        bit [2:0] ev = '0;
        int n0, top;
        if (rst || soft_rst) begin
            m_wr = 0; m_rd = 0; m_cnt = 0; m_swn = 0; m_up = 1; m_dout = 0; m_st = 6'h18;
        end else if (fifo_clr) begin
            m_wr = 0; m_rd = 0; m_cnt = 0; m_swn = 0; m_up = 1; m_st = 6'h18;
        end else begin
            case (mode_sel)
                2'd1: begin
                    n0 = m_cnt;
                    if (trig) begin
                        if (n0 == 0) ev[0] = 1;
                        else begin m_dout = m_mem[m_rd]; m_rd = (m_rd + 1) % 16; m_cnt--; end
                    end
                    if (wr_en) begin
                        if (n0 == 16) ev[1] = 1;
                        else begin m_mem[m_wr] = wr_data; m_wr = (m_wr + 1) % 16; m_cnt++; end
                    end
                end
                2'd2: begin
                    n0 = m_swn;
                    if (trig) begin
                        if (n0 == 0) ev[0] = 1;
                        else begin
                            m_dout = m_mem[m_rd];
                            top = n0 - 1;
                            if (top == 0) ev[2] = 1;
                            else if (m_up) begin m_rd++; if (m_rd == top) m_up = 0; end
                            else begin m_rd--; if (m_rd == 0) begin m_up = 1; ev[2] = 1; end end
                        end
                    end
                    if (wr_en) begin
                        if (n0 == 16) ev[1] = 1;
                        else begin m_mem[m_wr] = wr_data; m_wr = (m_wr + 1) % 16; m_swn++; end
                    end
                end
                default: if (wr_en) m_dout = wr_data;
            endcase
            m_st = sticky(m_st, ev, flag_w1c);
            if (mode_sel != 2'd2) begin
                m_st[4] = (m_cnt == 0);
                m_st[5] = (m_cnt == 16);
                m_st[3] = (m_cnt <= wm_level);
            end
        end
    endtask

    task automatic compare_all();
        bit sw = (mode_sel == 2'd2);
        chk((mode_sel == 2'd0 || mode_sel == 2'd3) ? "R1 dout" : "R2 dout", dout, m_dout);
        chk("R2 wr_ptr", wr_ptr, m_wr);
        chk(sw ? "R6 rd_ptr" : "R2 rd_ptr", rd_ptr, m_rd);
        chk("R3 underflow", status[0], m_st[0]);
        chk("R4 overflow", status[1], m_st[1]);
        chk("R7 sweep", status[2], m_st[2]);
        chk(sw ? "R10 watermark frozen" : "R8 watermark", status[3], m_st[3]);
        chk(sw ? "R10 empty frozen" : "R9 empty", status[4], m_st[4]);
        chk(sw ? "R10 full frozen" : "R9 full", status[5], m_st[5]);
        chk("R13 irq", irq, |(m_st & irq_en));
        chk("R13 dma_req", dma_req, (dma_en[0] & m_st[3]) | (dma_en[1] & m_st[4]));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic step(bit w, int d, bit t, bit [2:0] c);
        wr_en = w; wr_data = 14'(d); trig = t; flag_w1c = c;
        tick();
        wr_en = 0; trig = 0; flag_w1c = 0;
    endtask

    task automatic clear_to(bit [1:0] m);
        mode_sel = m; fifo_clr = 1; tick(); fifo_clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog act=hung exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        irq_en = 6'h3f; dma_en = 2'b11; wm_level = 5'd2;
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R9 reset status", status, 6'h18);
        chk("R12 reset dout", dout, 0);

        // R1: direct mode
        step(1, 14'h123, 0, 0);
        chk("R1 direct write", dout, 14'h123);
        step(0, 0, 1, 0);
        chk("R1 trigger ignored", dout, 14'h123);

        // R2 / R14 / R3: queue mode
        clear_to(2'd1);
        step(1, 11, 0, 0); step(1, 22, 0, 0); step(1, 33, 0, 0);
        chk("R8 watermark above level", status[3], 0);
        step(1, 44, 1, 0);
        chk("R14 dout", dout, 11);
        chk("R14 wr_ptr", wr_ptr, 4);
        chk("R14 rd_ptr", rd_ptr, 1);
        step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
        chk("R2 last out", dout, 44);
        step(0, 0, 1, 0);
        chk("R3 underflow set", status[0], 1);
        chk("R3 dout held", dout, 44);
        chk("R3 rd held", rd_ptr, 4);

        // R5: clear collides with a new underflow
        step(0, 0, 1, 3'b001);
        chk("R5 set beats clear", status[0], 1);
        step(0, 0, 0, 3'b001);
        chk("R5 clear alone", status[0], 0);

        // R4: overflow
        clear_to(2'd1);
        for (int i = 0; i < 16; i++) step(1, 100 + i, 0, 0);
        chk("R9 full", status[5], 1);
        step(1, 999, 0, 0);
        chk("R4 overflow set", status[1], 1);
        chk("R4 wr held", wr_ptr, 0);
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0);
        chk("R4 extra sample dropped", dout, 115);

        // R6 / R7 / R10: swing-back
        clear_to(2'd2);
        step(1, 10, 0, 0); step(1, 20, 0, 0); step(1, 30, 0, 0);
        chk("R10 empty frozen", status[4], 1);
        step(0, 0, 1, 0); chk("R6 rd 1", rd_ptr, 1);
        step(0, 0, 1, 0); chk("R6 rd 2", rd_ptr, 2);
        step(0, 0, 1, 0); chk("R6 rd back 1", rd_ptr, 1);
        chk("R7 not yet", status[2], 0);
        step(0, 0, 1, 0); chk("R6 rd 0", rd_ptr, 0);
        chk("R7 sweep on fourth", status[2], 1);
        chk("R6 dout", dout, 20);

        // R11 / R12
        mode_sel = 2'd1; fifo_clr = 1; wr_en = 1; wr_data = 14'd7; tick();
        fifo_clr = 0; wr_en = 0;
        chk("R11 status", status, 6'h18);
        chk("R11 wr_ptr", wr_ptr, 0);
        chk("R11 dout held", dout, 20);
        soft_rst = 1; tick(); soft_rst = 0;
        chk("R12 dout", dout, 0);

        // Random phase
        for (int s = 0; s < 40; s++) begin
            wm_level = 5'($urandom_range(0, 31));
            irq_en   = 6'($urandom);
            dma_en   = 2'($urandom);
            clear_to(2'($urandom_range(0, 3)));
            for (int c = 0; c < 120; c++) begin
                wr_en    = ($urandom_range(0, 99) < 55);
                wr_data  = 14'($urandom);
                trig     = ($urandom_range(0, 99) < 45);
                flag_w1c = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b000;
                fifo_clr = ($urandom_range(0, 99) == 0);
                soft_rst = ($urandom_range(0, 199) == 0);
                tick();
            end
            wr_en = 0; trig = 0; flag_w1c = 0; fifo_clr = 0; soft_rst = 0;
        end
        finish_run();
    end

endmodule